// File: doc/BRIEF.md
# Flow-Through Byte-Write Synchronous SRAM

This block is a single-clock synchronous static RAM with a small, parameterized depth and a word made of byte lanes (four by default, so 32 bits). Address, write data, the write controls and three chip enables are all captured on the rising clock edge. A write needs no separate strobe. The captured word is committed into the array at the next rising edge, so a read issued in the following cycle already sees it. Reads are flow-through: the word at the captured address reaches the output combinationally in the cycle that follows the capturing edge. There is no further output register.

The write controls decode in two levels. An active-low global write stores every lane. Otherwise, an active-low byte-write enable lets each active-low per-lane enable choose its own lane. The block is selected only when all three chip enables are asserted: `ce1_n` low, `ce2` high and `ce3_n` low. A small state register holds the kind of the captured cycle:

- `ST_DESEL`: not selected.
- `ST_READ`: a read.
- `ST_WRITE`: a write.

At every edge the state moves to whichever of the three the sampled inputs call for. Any state can move to any other, and reset forces `ST_DESEL`. The output stage drives the array word in `ST_READ` and drives zero in the other two states.

Top module: `fts_sram`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, `dout` is zero and no lane of the array is written.
- R2: On a selected cycle with `gw_n` low, all lanes of the word at the captured address are written from `din`, whatever `bwe_n` and `be_n` are.
- R3: On a selected cycle with `gw_n` high and `bwe_n` low, lane i (bits 8i+7:8i) is written if and only if `be_n[i]` is low. Lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R4: A byte write may update any subset of lanes. With `bwe_n` low and every `be_n` bit high, nothing is modified.
- R5: On a selected cycle with `gw_n` and `bwe_n` both high, the cycle is a read. No lane changes, and `dout` shows the stored word at the captured address in the cycle right after the capturing edge.
- R6: On a cycle where any chip enable is inactive, nothing is written, whatever the write controls are, and `dout` is zero for that cycle.
- R7: During a write cycle, `dout` is zero.
- R8: A read captured at the edge right after a write edge to the same address returns the newly written data.
- R9: The block is selected only when `ce1_n` is low, `ce2` is high and `ce3_n` is low. Each enable on its own can deselect the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| din | input | LANES*8 | Write data |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| be_n | input | LANES | Per-lane enables, active low, bit i for lane i |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| dout | output | LANES*8 | Flow-through read data, zero when not reading |

## Verification
The bench keeps a byte-wise shadow of the array and goes after the following corner cases:

- **Lane mapping.** Single-lane writes land in each lane. A design with swapped lane wiring would corrupt the neighbouring bytes.
- **Global-write override.** A global write is issued with every lane enable inactive. A design that let the lane enables gate a global write would leave the word stale.
- **Empty byte write.** A byte write with no lane enabled must change nothing.
- **Single deselecting enable.** Each chip enable is dropped on its own while a write is requested. A wrong polarity on any one enable either corrupts memory or blocks valid accesses.
- **Write then read.** Back-to-back write-then-read to one address catches a commit that lands one edge late.
- **Output value on non-reads.** Zero output during writes and deselects catches a design that holds the last read data.

// File: rtl/fts_sram_pkg.sv
package fts_sram_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } cyc_state_e;

    function automatic cyc_state_e classify(input logic sel, input logic gw_n,
                                            input logic bwe_n);
        if (!sel)               return ST_DESEL;
        else if (!gw_n || !bwe_n) return ST_WRITE;
        else                    return ST_READ;
    endfunction

endpackage

// File: rtl/fts_in_reg.sv
module fts_in_reg #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    localparam int DATA_W = LANES * fts_sram_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  be_n,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q,
    output logic              gw_n_q,
    output logic              bwe_n_q,
    output logic [LANES-1:0]  be_n_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            din_q   <= '0;
            gw_n_q  <= 1'b1;
            bwe_n_q <= 1'b1;
            be_n_q  <= '1;
        end else begin
            addr_q  <= addr;
            din_q   <= din;
            gw_n_q  <= gw_n;
            bwe_n_q <= bwe_n;
            be_n_q  <= be_n;
        end
    end

endmodule

// File: rtl/fts_lane_decode.sv
module fts_lane_decode #(
    parameter int LANES = 4
) (
    input  fts_sram_pkg::cyc_state_e state,
    input  logic                     gw_n_q,
    input  logic                     bwe_n_q,
    input  logic [LANES-1:0]         be_n_q,
    output logic [LANES-1:0]         lane_we
);
    import fts_sram_pkg::*;

    // Level one: global write claims every lane.
    // Level two: byte-write enable qualifies the per-lane enables.
    always_comb begin
        lane_we = '0;
        unique case (state)
            ST_WRITE: begin
                if (!gw_n_q)       lane_we = '1;
                else if (!bwe_n_q) lane_we = ~be_n_q;
                else               lane_we = '0;
            end
            ST_READ:  lane_we = '0;
            ST_DESEL: lane_we = '0;
            default:  lane_we = '0;
        endcase
    end

endmodule

// File: rtl/fts_byte_array.sv
module fts_byte_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    localparam int BW     = fts_sram_pkg::BYTE_W,
    localparam int DATA_W = LANES * BW,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] din_q,
    input  logic [LANES-1:0]  lane_we,
    output logic [DATA_W-1:0] rd_word
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BW-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) store[addr_q] <= din_q[g*BW +: BW];
        end

        assign rd_word[g*BW +: BW] = store[addr_q];
    end

endmodule

// File: rtl/fts_sram.sv
module fts_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    localparam int DATA_W = LANES * fts_sram_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  be_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    output logic [DATA_W-1:0] dout
);
    import fts_sram_pkg::*;

    cyc_state_e        state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q, rd_word;
    logic              gw_n_q, bwe_n_q;
    logic [LANES-1:0]  be_n_q, lane_we;
    logic              sel_in;

    assign sel_in   = !ce1_n && ce2 && !ce3_n;
    assign state_nx = classify(sel_in, gw_n, bwe_n);

    // State register: one cycle kind per captured edge.
    always_ff @(posedge clk) begin
        if (rst) state <= ST_DESEL;
        else     state <= state_nx;
    end

    fts_in_reg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_in_reg (
        .clk(clk), .rst(rst), .addr(addr), .din(din), .gw_n(gw_n),
        .bwe_n(bwe_n), .be_n(be_n), .addr_q(addr_q), .din_q(din_q),
        .gw_n_q(gw_n_q), .bwe_n_q(bwe_n_q), .be_n_q(be_n_q)
    );

    fts_lane_decode #(.LANES(LANES)) u_decode (
        .state(state), .gw_n_q(gw_n_q), .bwe_n_q(bwe_n_q),
        .be_n_q(be_n_q), .lane_we(lane_we)
    );

    fts_byte_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
        .clk(clk), .addr_q(addr_q), .din_q(din_q),
        .lane_we(lane_we), .rd_word(rd_word)
    );

    // Output process: flow-through on reads, zero otherwise.
    always_comb begin
        unique case (state)
            ST_READ:  dout = rd_word;
            ST_WRITE: dout = '0;
            ST_DESEL: dout = '0;
            default:  dout = '0;
        endcase
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (dout == '0 && lane_we == '0));

    // R2
    lane_all_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sel_in) && !$past(gw_n)) |-> lane_we == '1);

    // R3
    lane_sel_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sel_in) && $past(gw_n) && !$past(bwe_n)) |-> lane_we == ~$past(be_n));

    // R5
    read_flow_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sel_in) && $past(gw_n) && $past(bwe_n)) |-> (lane_we == '0 && dout == rd_word));

    // R6
    desel_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(sel_in) |-> (lane_we == '0 && dout == '0));

endmodule

// File: tb/fts_sram_tb.sv
`timescale 1ns/1ps
module fts_sram_tb;
    localparam int AW    = 6;
    localparam int NL    = 4;
    localparam int DW    = NL * 8;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [NL-1:0] be_n = '1;
    logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic [DW-1:0] dout;

    int            checks = 0, errors = 0;
    item_t         sb[$];
    logic [DW-1:0] shadow [DEPTH];

    always #4 clk = ~clk;

    fts_sram #(.ADDR_W(AW), .LANES(NL)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .din(din), .gw_n(gw_n),
        .bwe_n(bwe_n), .be_n(be_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .dout(dout)
    );

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                         input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dout=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle and queues the output expected after the edge.
    task automatic cyc(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic g, input logic b, input logic [NL-1:0] e,
                       input logic c1, input logic c2, input logic c3,
                       input string tag);
        item_t it;
        logic  sel;
        @(negedge clk);
        addr = a; din = d; gw_n = g; bwe_n = b; be_n = e;
        ce1_n = c1; ce2 = c2; ce3_n = c3;
        sel = !c1 && c2 && !c3;
        it.tag = tag;
        if (sel && (!g || !b)) begin
            for (int i = 0; i < NL; i++)
                if (!g || !e[i]) shadow[a][i*8 +: 8] = d[i*8 +: 8];
            it.exp = '0;
        end else if (sel) begin
            it.exp = shadow[a];
        end else begin
            it.exp = '0;
        end
        sb.push_back(it);
    endtask

    task automatic wr_all(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [NL-1:0] e, input string tag);
        cyc(a, d, 1'b0, 1'b1, e, 1'b0, 1'b1, 1'b0, tag);
    endtask

    task automatic wr_byte(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [NL-1:0] e, input string tag);
        cyc(a, d, 1'b1, 1'b0, e, 1'b0, 1'b1, 1'b0, tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        cyc(a, $urandom, 1'b1, 1'b1, $urandom, 1'b0, 1'b1, 1'b0, tag);
    endtask

    // Monitor: compares after each edge.
    always @(posedge clk) begin
        #2;
        if (!rst && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(dout, it.exp, it.tag);
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 check(dout, '0, "R1 in reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2 check(dout, '0, "R1 after reset");

        // R2: fill with global writes while every lane enable is inactive
        for (int k = 0; k < DEPTH; k++) wr_all(k[AW-1:0], $urandom, 4'b1111, "R2 fill");
        for (int k = 0; k < 4; k++) rd(k[AW-1:0], "R2 readback");

        // R3: single-lane byte writes
        for (int i = 0; i < NL; i++) begin
            wr_byte(6'd10, {4{8'hA0 + 8'(i)}}, ~(4'b1 << i), "R7 write");
            rd(6'd10, "R3 lane");
        end

        // R4: empty mask and multi-lane subsets
        wr_byte(6'd11, 32'hDEADBEEF, 4'b1111, "R7 write");
        rd(6'd11, "R4 empty mask");
        wr_byte(6'd11, 32'h12345678, 4'b0101, "R7 write");
        rd(6'd11, "R4 two lanes");
        wr_byte(6'd11, 32'hCAFEF00D, 4'b0000, "R7 write");
        rd(6'd11, "R4 all lanes");

        // R9 / R6: each enable alone deselects, even with a write asserted
        cyc(6'd12, 32'h11111111, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, "R6 ce1 off");
        rd(6'd12, "R9 ce1");
        cyc(6'd12, 32'h22222222, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, "R6 ce2 off");
        rd(6'd12, "R9 ce2");
        cyc(6'd12, 32'h33333333, 1'b1, 1'b1, 4'b1111, 1'b0, 1'b1, 1'b1, "R6 read deselected");
        cyc(6'd12, 32'h44444444, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b1, "R6 ce3 off");
        rd(6'd12, "R9 ce3");

        // R8: back-to-back write then read, same address
        wr_all(6'd20, 32'h0BADC0DE, 4'b0000, "R7 write");
        rd(6'd20, "R8 write-read");
        wr_byte(6'd20, 32'h77000000, 4'b0111, "R7 write");
        rd(6'd20, "R8 byte write-read");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned op = $urandom_range(0, 3);
            logic [AW-1:0] a = AW'($urandom);
            case (op)
                0: wr_all(a, $urandom, NL'($urandom), "R2 random");
                1: wr_byte(a, $urandom, NL'($urandom), "R3 random");
                2: rd(a, "R5 random");
                default: cyc(a, $urandom, 1'($urandom), 1'($urandom), NL'($urandom),
                             1'b1, 1'($urandom), 1'($urandom), "R6 random");
            endcase
        end
        for (int k = 0; k < DEPTH; k++) rd(k[AW-1:0], "R5 final sweep");

        repeat (3) @(posedge clk);
        #3;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule